// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block turns one block-transfer command into a series of word-sized bus
transactions. A one-cycle start pulse supplies a base address, a register-list
bitmask, the direction (load or store), an up/down flag and three mode flags. The
block then visits the selected registers from the lowest index to the highest.
For each one it issues a single word transfer on a valid/ready bus port, and the
address moves on by 4 after each transfer. Store data is read combinationally from a
register-file read port. Load data is written back through a registered
register-file write port.

Two list formats are supported. The full format uses all 16 list bits. The
compact format uses only the low 8 bits, plus an optional trailing transfer that
loads the program counter or stores the link register. An empty list still moves
data: it transfers the program counter once and moves the base by 0x40. A user-bank
flag steers register traffic to the user register bank, or requests a status
restore. At the end the block reports the written-back base address together with
a one-cycle done pulse.

Back-pressure: `bus_valid` stays high, with `bus_addr`, `bus_write` and `bus_wdata`
stable, until `bus_ready` is seen high at a clock edge. A transfer completes on the
edge where both are high. `bus_rdata` is sampled on that edge only. The bus port
has no other flow control.

Top module: `mrt_sequencer`

## Requirements
- R1: Transfers follow ascending register index, one word transfer per selected register, and the address grows by 4 between consecutive transfers. Counting up, the first address is the base. Counting down, the first address is base minus 4 times the transfer count. `bus_write` is 1 for a store and 0 for a load.
- R2: While `bus_valid` is high and `bus_ready` is low, the request (address, direction, store data) is held unchanged. A transfer completes only on a clock edge where both are high.
- R3: In full format, a stored program counter (register 15) is the register-file value plus 8. Every other stored register is sent unmodified.
- R4: A load writes `bus_rdata` to the register file in the cycle after its acknowledge. A loaded program counter has bits 1:0 cleared in full format, and only bit 0 cleared in compact format.
- R5: A list with no selected transfer performs one program-counter transfer. Its span counts as 16 words: it starts at the base when counting up and at base minus 0x40 when counting down, and the writeback is base plus or minus 0x40. In compact format the stored program counter is the register-file value plus 4.
- R6: In compact format, list bits 15:8 are ignored. The extra flag adds one final transfer after the list: register 15 on a load, register 14 on a store. It counts as one more word.
- R7: With the user flag, in full format with a non-empty list: a load whose list excludes register 15 writes to the user bank (`rf_wr_user`), and a store always reads from the user bank (`rf_rd_user`). A load that includes register 15 writes to the normal bank and pulses `psr_restore` with `done`, in the cycle the program-counter write appears. The flag has no effect in compact format or on an empty list.
- R8: `wb_en` pulses together with `done`. `wb_addr` then equals the base plus or minus 4 times the number of transfers.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge. `busy` is high from the cycle after an accepted start through the `done` cycle. A start pulse while `busy` is high is ignored.
- R10: After reset the block is idle: `busy`, `done`, `bus_valid`, `rf_wr_en`, `wb_en` and `psr_restore` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse, taken only when idle |
| start_base | input | 32 | Base address |
| start_list | input | 16 | Register-list bitmask |
| start_load | input | 1 | 1 = load, 0 = store |
| start_up | input | 1 | 1 = count up, 0 = count down |
| start_compact | input | 1 | Compact 8-bit list format |
| start_extra | input | 1 | Compact format: trailing PC load or LR store |
| start_user | input | 1 | User-bank / status-restore flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request accepted |
| bus_addr | output | 32 | Word address of the transfer |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Store data |
| bus_rdata | input | 32 | Load data, sampled at acknowledge |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_user | output | 1 | Read from user bank |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_user | output | 1 | Write to user bank |
| rf_wr_data | output | 32 | Register-file write data |
| wb_en | output | 1 | Base writeback strobe |
| wb_addr | output | 32 | Written-back base address |
| psr_restore | output | 1 | Copy saved status to current status |

## Verification
Sparse, dense and all-ones full-format lists, run in both directions, separate ascending ordering and the address arithmetic from a single-transfer case. Lists containing register 15 separate the store offset and load masking from plain register traffic. Empty lists in both formats, and compact lists with high-order garbage and the extra flag, separate the 0x40 span and the compact PC/LR choice from the normal popcount path. User-flag commands with and without register 15 separate bank steering from status restore. A randomly stalling ready and a start pulse injected mid-command exercise request holding and start rejection.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } mrt_state_e;
endpackage

// File: rtl/mrt_lowest.sv
module mrt_lowest #(
  parameter int W  = 17,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mrt_span.sv
module mrt_span #(
  parameter int AW          = 32,
  parameter int LIST_W      = 16,
  parameter int COMPACT_W   = 8,
  parameter int EMPTY_WORDS = 16,
  parameter int STRIDE      = 4,
  parameter int SLOTS       = LIST_W + 1
) (
  input  logic [AW-1:0]     base,
  input  logic [LIST_W-1:0] list,
  input  logic              compact,
  input  logic              extra,
  input  logic              up,
  output logic [SLOTS-1:0]  mask,
  output logic              empty,
  output logic [AW-1:0]     first_addr,
  output logic [AW-1:0]     wb_addr
);
  localparam int CW = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] raw;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    bytes;

  for (genvar g = 0; g < LIST_W; g++) begin : g_slot
    if (g < COMPACT_W) begin : g_low
      assign raw[g] = list[g];
    end else begin : g_high
      assign raw[g] = list[g] & ~compact;
    end
  end
  assign raw[LIST_W] = compact & extra;

  assign empty = (raw == '0);
  assign mask  = empty ? (SLOTS'(1) << LIST_W) : raw;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < SLOTS; i++) cnt = cnt + CW'(raw[i]);
  end

  assign bytes      = (empty ? AW'(EMPTY_WORDS) : AW'(cnt)) * AW'(STRIDE);
  assign first_addr = up ? base : base - bytes;
  assign wb_addr    = up ? base + bytes : base - bytes;
endmodule

// File: rtl/mrt_sequencer.sv
module mrt_sequencer
  import mrt_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int LIST_W      = 16,
  parameter int COMPACT_W   = 8,
  parameter int EMPTY_WORDS = 16,
  parameter int STRIDE      = 4,
  parameter int PC_OFS_FULL = 8,
  parameter int PC_OFS_CMP  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [AW-1:0]             start_base,
  input  logic [LIST_W-1:0]         start_list,
  input  logic                      start_load,
  input  logic                      start_up,
  input  logic                      start_compact,
  input  logic                      start_extra,
  input  logic                      start_user,
  output logic                      busy,
  output logic                      done,
  output logic                      bus_valid,
  input  logic                      bus_ready,
  output logic [AW-1:0]             bus_addr,
  output logic                      bus_write,
  output logic [DW-1:0]             bus_wdata,
  input  logic [DW-1:0]             bus_rdata,
  output logic [$clog2(LIST_W)-1:0] rf_rd_idx,
  output logic                      rf_rd_user,
  input  logic [DW-1:0]             rf_rd_data,
  output logic                      rf_wr_en,
  output logic [$clog2(LIST_W)-1:0] rf_wr_idx,
  output logic                      rf_wr_user,
  output logic [DW-1:0]             rf_wr_data,
  output logic                      wb_en,
  output logic [AW-1:0]             wb_addr,
  output logic                      psr_restore
);
  localparam int SLOTS  = LIST_W + 1;
  localparam int IW     = $clog2(LIST_W);
  localparam int SW     = $clog2(SLOTS);
  localparam int PC_IDX = LIST_W - 1;
  localparam int LR_IDX = LIST_W - 2;

  mrt_state_e       state_q;
  logic [SLOTS-1:0] mask_q;
  logic [AW-1:0]    addr_q, wb_q;
  logic             load_q, compact_q, user_rd_q, user_wr_q, psr_q;
  logic [IW-1:0]    special_q;

  logic [SLOTS-1:0] s_mask;
  logic             s_empty, user_eff;
  logic [AW-1:0]    s_first, s_wb;
  logic [SW-1:0]    slot;
  logic [IW-1:0]    cur_idx;
  logic             cur_pc, ack;
  logic [SLOTS-1:0] mask_next;
  logic [DW-1:0]    keep;

  mrt_span #(
    .AW(AW), .LIST_W(LIST_W), .COMPACT_W(COMPACT_W),
    .EMPTY_WORDS(EMPTY_WORDS), .STRIDE(STRIDE)
  ) i_span (
    .base(start_base), .list(start_list), .compact(start_compact),
    .extra(start_extra), .up(start_up), .mask(s_mask), .empty(s_empty),
    .first_addr(s_first), .wb_addr(s_wb)
  );

  mrt_lowest #(.W(SLOTS), .IW(SW)) i_lowest (.vec(mask_q), .idx(slot));

  assign user_eff  = start_user & ~start_compact & ~s_empty;
  assign cur_idx   = (slot == SW'(LIST_W)) ? special_q : slot[IW-1:0];
  assign cur_pc    = (cur_idx == IW'(PC_IDX));
  assign ack       = (state_q == ST_XFER) & bus_ready;
  assign mask_next = mask_q & ~(SLOTS'(1) << slot);
  assign keep      = cur_pc ? (compact_q ? ~DW'(1) : ~DW'(3)) : '1;

  assign rf_rd_idx  = cur_idx;
  assign rf_rd_user = user_rd_q;
  assign bus_wdata  = rf_rd_data +
                      (cur_pc ? DW'(compact_q ? PC_OFS_CMP : PC_OFS_FULL) : '0);
  assign bus_valid  = (state_q == ST_XFER);
  assign bus_addr   = addr_q;
  assign bus_write  = ~load_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign wb_en      = done;
  assign wb_addr    = wb_q;
  assign psr_restore = done & psr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mask_q     <= '0;
      addr_q     <= '0;
      wb_q       <= '0;
      load_q     <= 1'b0;
      compact_q  <= 1'b0;
      user_rd_q  <= 1'b0;
      user_wr_q  <= 1'b0;
      psr_q      <= 1'b0;
      special_q  <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_user <= 1'b0;
      rf_wr_data <= '0;
    end else begin
      rf_wr_en <= ack & load_q;
      if (ack & load_q) begin
        rf_wr_idx  <= cur_idx;
        rf_wr_user <= user_wr_q;
        rf_wr_data <= bus_rdata & keep;
      end
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q   <= ST_XFER;
          mask_q    <= s_mask;
          addr_q    <= s_first;
          wb_q      <= s_wb;
          load_q    <= start_load;
          compact_q <= start_compact;
          user_rd_q <= user_eff;
          user_wr_q <= user_eff & ~start_list[PC_IDX];
          psr_q     <= user_eff & start_load & start_list[PC_IDX];
          special_q <= (s_empty | start_load) ? IW'(PC_IDX) : IW'(LR_IDX);
        end
        ST_XFER: if (bus_ready) begin
          mask_q <= mask_next;
          addr_q <= addr_q + AW'(STRIDE);
          if (mask_next == '0) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write))); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> (!bus_valid || bus_addr == $past(bus_addr) + AW'(STRIDE))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_valid && bus_ready)); // R9
  AST_PSR_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> (rf_wr_en && rf_wr_idx == IW'(PC_IDX) && !rf_wr_user)); // R7
  AST_WB_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !bus_valid); // R8
endmodule

// File: tb/test_mrt_sequencer.sv
module test_mrt_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RD_XOR = 32'h5A5A_A5A7;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] start_base = 0;
  logic [15:0] start_list = 0;
  logic start_load = 0, start_up = 0, start_compact = 0, start_extra = 0, start_user = 0;
  logic busy, done, bus_valid, bus_ready, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, rf_rd_data, rf_wr_data, wb_addr;
  logic [3:0] rf_rd_idx, rf_wr_idx;
  logic rf_rd_user, rf_wr_en, rf_wr_user, wb_en, psr_restore;

  int n_cmp = 0, n_bad = 0;
  bit ready_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] rf_fn(int idx, bit u);
    return 32'h1000_0000 * (u ? 3 : 1) + 32'h0001_0101 * idx + 32'h20;
  endfunction

  assign rf_rd_data = rf_fn(int'(rf_rd_idx), rf_rd_user);
  assign bus_rdata  = bus_addr ^ RD_XOR;

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_ready <= ready_rand ? lfsr[3] : 1'b1;
  end
  initial bus_ready = 1'b1;

  mrt_sequencer i_mrt_sequencer (
    .clk, .rst_n, .start, .start_base, .start_list, .start_load, .start_up,
    .start_compact, .start_extra, .start_user, .busy, .done, .bus_valid,
    .bus_ready, .bus_addr, .bus_write, .bus_wdata, .bus_rdata, .rf_rd_idx,
    .rf_rd_user, .rf_rd_data, .rf_wr_en, .rf_wr_idx, .rf_wr_user, .rf_wr_data,
    .wb_en, .wb_addr, .psr_restore
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_state = 0;
  logic [31:0] q_addr[$], q_wdata[$], q_keep[$];
  bit q_wr[$], q_wuser[$];
  int q_idx[$];
  string q_tag[$];
  logic [31:0] m_wb;
  string m_wb_tag;
  bit m_psr;
  bit m_pend, m_pend_user;
  int m_pend_idx;
  logic [31:0] m_pend_data;
  string m_pend_tag;

  task automatic model_start();
    int regs[$];
    int span;
    bit empty, ueff;
    logic [31:0] first;
    int lim = start_compact ? 8 : 16;
    for (int i = 0; i < lim; i++) if (start_list[i]) regs.push_back(i);
    if (start_compact && start_extra) regs.push_back(start_load ? 15 : 14);
    empty = (regs.size() == 0);
    if (empty) begin regs.push_back(15); span = 16; end else span = regs.size();
    ueff  = start_user && !start_compact && !empty;
    first = start_up ? start_base : start_base - 32'(4 * span);
    m_wb  = start_up ? start_base + 32'(4 * span) : start_base - 32'(4 * span);
    m_wb_tag = empty ? "R5 wb_addr" : "R8 wb_addr";
    m_psr = ueff && start_load && start_list[15];
    for (int k = 0; k < regs.size(); k++) begin
      int r = regs[k];
      string t;
      logic [31:0] wd = rf_fn(r, ueff);
      if (empty) t = "R5";
      else if (start_compact && start_extra && k == regs.size() - 1) t = "R6";
      else if (r == 15) t = start_load ? "R4" : "R3";
      else if (ueff) t = "R7";
      else t = "R1";
      if (r == 15) wd = wd + (start_compact ? 32'd4 : 32'd8);
      q_addr.push_back(first + 32'(4 * k));
      q_wr.push_back(!start_load);
      q_wdata.push_back(wd);
      q_idx.push_back(r);
      q_wuser.push_back(ueff && !start_list[15]);
      q_keep.push_back(r == 15 ? (start_compact ? ~32'd1 : ~32'd3) : 32'hFFFF_FFFF);
      q_tag.push_back(t);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pend = 0;
      q_addr.delete(); q_wr.delete(); q_wdata.delete(); q_idx.delete();
      q_wuser.delete(); q_keep.delete(); q_tag.delete();
    end else begin
      chk("R9 busy", 32'(busy), 32'(m_state != 0));
      chk("R9 done", 32'(done), 32'(m_state == 2));
      chk("R2 bus_valid", 32'(bus_valid), 32'(m_state == 1));
      if (m_state == 1 && bus_valid) begin
        chk({q_tag[0], " bus_addr"}, bus_addr, q_addr[0]);
        chk("R1 bus_write", 32'(bus_write), 32'(q_wr[0]));
        if (q_wr[0]) chk({q_tag[0], " bus_wdata"}, bus_wdata, q_wdata[0]);
      end
      chk("R4 rf_wr_en", 32'(rf_wr_en), 32'(m_pend));
      if (m_pend && rf_wr_en) begin
        chk({m_pend_tag, " rf_wr_idx"}, 32'(rf_wr_idx), 32'(m_pend_idx));
        chk("R7 rf_wr_user", 32'(rf_wr_user), 32'(m_pend_user));
        chk({m_pend_tag, " rf_wr_data"}, rf_wr_data, m_pend_data);
      end
      chk("R8 wb_en", 32'(wb_en), 32'(m_state == 2));
      if (m_state == 2 && wb_en) chk(m_wb_tag, wb_addr, m_wb);
      chk("R7 psr_restore", 32'(psr_restore), 32'(m_state == 2 && m_psr));
      m_pend = 0;
      case (m_state)
        1: if (bus_ready) begin
          if (!q_wr[0]) begin
            m_pend = 1; m_pend_idx = q_idx[0]; m_pend_user = q_wuser[0];
            m_pend_data = (q_addr[0] ^ RD_XOR) & q_keep[0]; m_pend_tag = q_tag[0];
          end
          void'(q_addr.pop_front()); void'(q_wr.pop_front()); void'(q_wdata.pop_front());
          void'(q_idx.pop_front()); void'(q_wuser.pop_front()); void'(q_keep.pop_front());
          void'(q_tag.pop_front());
          if (q_addr.size() == 0) m_state = 2;
        end
        2: m_state = 0;
        default: if (start) begin model_start(); m_state = 1; end
      endcase
    end
  end

  task automatic issue(logic [31:0] base, logic [15:0] list, bit ld, bit up,
                       bit cmp, bit ext, bit usr, bit wait_idle);
    @(posedge clk); #2;
    start_base = base; start_list = list; start_load = ld; start_up = up;
    start_compact = cmp; start_extra = ext; start_user = usr; start = 1;
    @(posedge clk); #2;
    start = 0;
    if (wait_idle) begin
      @(negedge clk);
      while (busy) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 bus_valid", 32'(bus_valid), 0);
    chk("R10 rf_wr_en", 32'(rf_wr_en), 0);
    chk("R10 wb_en", 32'(wb_en), 0);
    chk("R10 psr_restore", 32'(psr_restore), 0);
    // R1 R3: sparse store up with PC
    issue(32'h0300_0100, 16'h8421, 0, 1, 0, 0, 0, 1);
    // R1 R4: load down
    issue(32'h0200_0800, 16'h00F3, 1, 0, 0, 0, 0, 1);
    // R7: user load with PC -> status restore
    issue(32'h0300_0040, 16'h8003, 1, 1, 0, 0, 1, 1);
    // R7: user load without PC -> user bank
    issue(32'h0300_0080, 16'h0006, 1, 0, 0, 0, 1, 1);
    // R7: user store -> reads user bank
    issue(32'h0300_0200, 16'h8001, 0, 1, 0, 0, 1, 1);
    // R5: empty full-format store up, load down
    issue(32'h0200_1000, 16'h0000, 0, 1, 0, 0, 0, 1);
    issue(32'h0200_1000, 16'h0000, 1, 0, 0, 0, 1, 1);
    // R6: compact store with LR, garbage upper bits
    issue(32'h0300_0300, 16'hAB05, 0, 1, 1, 1, 1, 1);
    // R6 R4: compact load with PC, down
    issue(32'h0300_0400, 16'h7F81, 1, 0, 1, 1, 0, 1);
    // R5: compact empty store and load
    issue(32'h0300_0500, 16'hFF00, 0, 1, 1, 0, 0, 1);
    issue(32'h0300_0600, 16'h0000, 1, 0, 1, 0, 0, 1);
    // R2: stalling bus, full list both directions
    ready_rand = 1;
    issue(32'h0200_2000, 16'hFFFF, 1, 1, 0, 0, 0, 1);
    issue(32'h0200_3000, 16'hFFFF, 0, 0, 0, 0, 0, 1);
    issue(32'h0200_4000, 16'h0001, 0, 1, 0, 0, 0, 1);
    // R9: start while busy is ignored
    issue(32'h0200_5000, 16'h00FF, 0, 1, 0, 0, 0, 0);
    issue(32'h0900_0000, 16'h1111, 1, 0, 0, 0, 0, 1);
    ready_rand = 0;
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule